// File: doc/BRIEF.md
# Dual-Channel Parallel DAC Write Sequencer

This block sits between an on-chip requester and the parallel load port of an external dual 8-bit multiplying converter. The converter has two channels behind one shared 8-bit data bus. A channel-select line picks which channel a write lands in. The channel's latch follows the bus while the active-low chip-select and active-low write strobe are both low, and it freezes when either one returns high.

The requester hands over one write at a time through a valid/ready pair. Each write carries a channel and a value. The value is either a raw ladder code or an attenuation given as a count of half-decibel steps, which the block turns into a code. The sequencer then plays out the bus cycle: select asserted with channel and data, strobe low, strobe high, a hold interval, then release. Every interval is a whole number of system clocks, rounded up from the converter's nanosecond limits at the clock period given as a parameter. A one-cycle done pulse closes each write.

Top module: `dual_dac_wr_seq`

## Requirements
- R1: After synchronous reset, chip-select and strobe are high, the data bus and channel line are zero, busy and done are low, and ready is high.
- R2: A request is taken on a clock edge where valid and ready are both high. From the next cycle, ready is low and busy is high for exactly max(SETUP, PULSE+1)+HOLD cycles.
- R3: The strobe is low only while chip-select is low. Chip-select, channel line and data are driven for at least SETUP = ceil(T_setup/period) cycles before the strobe rises, where T_setup is 160 ns, or 210 ns when WIDE_TEMP=1.
- R4: The strobe stays low for exactly PULSE = ceil(T_pulse/period) cycles, where T_pulse is 150 ns, or 210 ns when WIDE_TEMP=1.
- R5: After the strobe rises, chip-select stays low for HOLD = ceil(10 ns/period) cycles. Channel line and data do not change at any time while chip-select is low.
- R6: In the cycle after busy falls, done is high for exactly one cycle.
- R7: Channel line low (request channel 0) writes channel A. Channel line high (request channel 1) writes channel B. The other channel's contents do not change.
- R8: With gain mode off, the 8-bit request value reaches the selected channel unchanged, including 0x00 and 0xFF.
- R9: With gain mode on, the value is a half-dB step count n. The code is round(256·10^(-n/40)) clamped to 255: n=0 gives 255, n=12 gives 128, n=20 gives 81, n=24 gives 64, n=31 gives 43.
- R10: In gain mode, step counts above 31 give the 15.5 dB code, 43.
- R11: Requests presented while busy are ignored. They start no bus cycle and change neither channel.
- R12: With WIDE_TEMP=1, at the default 8 ns clock, the strobe is low for 27 cycles and busy lasts 30 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_chan | input | 1 | Target channel: 0 = A, 1 = B |
| req_is_gain | input | 1 | 1: value is a half-dB step count; 0: raw code |
| req_value | input | 8 | Raw code or step count |
| busy | output | 1 | Bus cycle in progress |
| done | output | 1 | One-cycle pulse after a finished write |
| dac_cs_n | output | 1 | Converter chip-select, active low |
| dac_wr_n | output | 1 | Converter write strobe, active low |
| dac_sel_b | output | 1 | Channel line: 0 = A, 1 = B |
| dac_db | output | 8 | Shared data bus |

## Verification
A wrong phase state or a miscounted phase timer shows up in the same write. The strobe width, the chip-select lead before the strobe edge, the tail after it, or the busy length differs by at least one cycle from the count derived from the nanosecond limits. A wrong captured word or a bad step-to-code entry appears as a wrong value in the modelled channel latch as soon as that write finishes. A wrong select decode appears as a change in the channel that should have held. A leak of requests during busy shows up as an extra bus cycle or an altered latch before the next accepted write.

// File: rtl/dacseq_pkg.sv
package dacseq_pkg;

    localparam int CODE_W      = 8;
    localparam int STEP_W      = 5;
    localparam int STEP_LAST   = 31;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_STROBE,
        PH_HOLD,
        PH_DONE
    } phase_e;

    typedef struct packed {
        logic              chan_b;
        logic [CODE_W-1:0] code;
    } dac_word_t;

    // Round a nanosecond limit up to whole clock periods (period in ps).
    function automatic int ns_to_cycles(input int ns, input int period_ps);
        return (ns * 1000 + period_ps - 1) / period_ps;
    endfunction

    // Half-dB step count to ladder code: round(256 * 10^(-n/40)), max 255.
    function automatic logic [CODE_W-1:0] step_to_code(input logic [STEP_W-1:0] n);
        logic [CODE_W-1:0] c;
        case (n)
            5'd0:  c = 8'd255;  5'd1:  c = 8'd242;  5'd2:  c = 8'd228;  5'd3:  c = 8'd215;
            5'd4:  c = 8'd203;  5'd5:  c = 8'd192;  5'd6:  c = 8'd181;  5'd7:  c = 8'd171;
            5'd8:  c = 8'd162;  5'd9:  c = 8'd152;  5'd10: c = 8'd144;  5'd11: c = 8'd136;
            5'd12: c = 8'd128;  5'd13: c = 8'd121;  5'd14: c = 8'd114;  5'd15: c = 8'd108;
            5'd16: c = 8'd102;  5'd17: c = 8'd96;   5'd18: c = 8'd91;   5'd19: c = 8'd86;
            5'd20: c = 8'd81;   5'd21: c = 8'd76;   5'd22: c = 8'd72;   5'd23: c = 8'd68;
            5'd24: c = 8'd64;   5'd25: c = 8'd61;   5'd26: c = 8'd57;   5'd27: c = 8'd54;
            5'd28: c = 8'd51;   5'd29: c = 8'd48;   5'd30: c = 8'd46;   default: c = 8'd43;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/dacseq_code_map.sv
module dacseq_code_map
    import dacseq_pkg::*;
(
    input  logic              is_gain,
    input  logic [CODE_W-1:0] value,
    output logic [CODE_W-1:0] code
);
    logic [STEP_W-1:0] step_sat;

    always_comb begin
        if (value > CODE_W'(STEP_LAST)) step_sat = STEP_W'(STEP_LAST);
        else                            step_sat = value[STEP_W-1:0];
        code = is_gain ? step_to_code(step_sat) : value;
    end

    // Steps past the table end land on the deepest attenuation code.
    always_comb begin
        if (is_gain === 1'b1 && value > 8'd31 && value !== 'x)
            assert_gain_saturation_R10: assert (code == 8'd43);
    end

endmodule

// File: rtl/dacseq_phase_timer.sv
module dacseq_phase_timer #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)               cnt <= '0;
        else if (load)         cnt <= load_val;
        else if (cnt != '0)    cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/dacseq_word_reg.sv
module dacseq_word_reg
    import dacseq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      capture,
    input  dac_word_t d,
    output dac_word_t q
);
    always_ff @(posedge clk) begin
        if (rst)          q <= '0;
        else if (capture) q <= d;
    end
endmodule

// File: rtl/dual_dac_wr_seq.sv
module dual_dac_wr_seq
    import dacseq_pkg::*;
#(
    parameter int CLK_PERIOD_PS = 8000,
    parameter bit WIDE_TEMP     = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    output logic       req_ready,
    input  logic       req_chan,
    input  logic       req_is_gain,
    input  logic [7:0] req_value,
    output logic       busy,
    output logic       done,
    output logic       dac_cs_n,
    output logic       dac_wr_n,
    output logic       dac_sel_b,
    output logic [7:0] dac_db
);
    localparam int SETUP_NS  = WIDE_TEMP ? 210 : 160;
    localparam int PULSE_NS  = WIDE_TEMP ? 210 : 150;
    localparam int HOLD_NS   = 10;
    localparam int SETUP_CYC = ns_to_cycles(SETUP_NS, CLK_PERIOD_PS);
    localparam int PULSE_CYC = ns_to_cycles(PULSE_NS, CLK_PERIOD_PS);
    localparam int HOLD_CYC  = ns_to_cycles(HOLD_NS, CLK_PERIOD_PS);
    localparam int ADDR_CYC  = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC - PULSE_CYC : 1;
    localparam int MAX_CYC   = (PULSE_CYC > ADDR_CYC) ? PULSE_CYC : ADDR_CYC;
    localparam int CNT_W     = $clog2(MAX_CYC + 1);

    phase_e            phase;
    logic              accept;
    logic              t_load;
    logic [CNT_W-1:0]  t_val;
    logic              t_expired;
    logic [CODE_W-1:0] mapped_code;
    dac_word_t         word_in, word_q;

    assign req_ready = (phase == PH_IDLE);
    assign accept    = req_valid && req_ready;

    dacseq_code_map u_map (
        .is_gain (req_is_gain),
        .value   (req_value),
        .code    (mapped_code)
    );

    assign word_in = '{chan_b: req_chan, code: mapped_code};

    dacseq_word_reg u_word (
        .clk     (clk),
        .rst     (rst),
        .capture (accept),
        .d       (word_in),
        .q       (word_q)
    );

    dacseq_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (t_load),
        .load_val (t_val),
        .expired  (t_expired)
    );

    // Timer reload at every phase entry, loaded with length minus one.
    always_comb begin
        t_load = 1'b0;
        t_val  = '0;
        unique case (phase)
            PH_IDLE:   if (accept)    begin t_load = 1'b1; t_val = CNT_W'(ADDR_CYC - 1);  end
            PH_ADDR:   if (t_expired) begin t_load = 1'b1; t_val = CNT_W'(PULSE_CYC - 1); end
            PH_STROBE: if (t_expired) begin t_load = 1'b1; t_val = CNT_W'(HOLD_CYC - 1);  end
            default:   ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
        end else begin
            unique case (phase)
                PH_IDLE:   if (accept)    phase <= PH_ADDR;
                PH_ADDR:   if (t_expired) phase <= PH_STROBE;
                PH_STROBE: if (t_expired) phase <= PH_HOLD;
                PH_HOLD:   if (t_expired) phase <= PH_DONE;
                default:                  phase <= PH_IDLE;
            endcase
        end
    end

    assign busy      = (phase == PH_ADDR) || (phase == PH_STROBE) || (phase == PH_HOLD);
    assign done      = (phase == PH_DONE);
    assign dac_cs_n  = !busy;
    assign dac_wr_n  = (phase != PH_STROBE);
    assign dac_sel_b = word_q.chan_b;
    assign dac_db    = word_q.code;

    // ---------------- checker state and assertions ----------------
    logic        past_ok;
    logic [15:0] cs_low_cnt, wr_low_cnt, tail_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            past_ok    <= 1'b0;
            cs_low_cnt <= '0;
            wr_low_cnt <= '0;
            tail_cnt   <= '0;
        end else begin
            past_ok    <= 1'b1;
            cs_low_cnt <= dac_cs_n ? '0 : cs_low_cnt + 1'b1;
            wr_low_cnt <= dac_wr_n ? '0 : wr_low_cnt + 1'b1;
            tail_cnt   <= (dac_cs_n || !dac_wr_n) ? '0 : tail_cnt + 1'b1;
        end
    end

    assert_strobe_in_select_R3: assert property (@(posedge clk) disable iff (rst || !past_ok)
        !dac_wr_n |-> !dac_cs_n);

    assert_setup_window_R3: assert property (@(posedge clk) disable iff (rst || !past_ok)
        $rose(dac_wr_n) |-> (cs_low_cnt >= 16'(SETUP_CYC)));

    assert_strobe_width_R4: assert property (@(posedge clk) disable iff (rst || !past_ok)
        $rose(dac_wr_n) |-> (wr_low_cnt == 16'(PULSE_CYC)));

    assert_hold_window_R5: assert property (@(posedge clk) disable iff (rst || !past_ok)
        $rose(dac_cs_n) |-> (tail_cnt >= 16'(HOLD_CYC)));

    assert_bus_stable_R5: assert property (@(posedge clk) disable iff (rst || !past_ok)
        (!dac_cs_n && $past(!dac_cs_n)) |-> ($stable(dac_db) && $stable(dac_sel_b)));

    assert_done_after_busy_R6: assert property (@(posedge clk) disable iff (rst || !past_ok)
        $fell(busy) |-> done);

    assert_done_single_R6: assert property (@(posedge clk) disable iff (rst || !past_ok)
        done |=> !done);

    assert_busy_blocks_R11: assert property (@(posedge clk) disable iff (rst || !past_ok)
        busy |-> !req_ready);

endmodule

// File: tb/test_dual_dac_wr_seq.sv
module tb_dac_latch_model (
    input  logic       clk,
    input  logic       cs_n,
    input  logic       wr_n,
    input  logic       sel_b,
    input  logic [7:0] db,
    output logic [7:0] lat_a,
    output logic [7:0] lat_b,
    output int         meas_setup,
    output int         meas_pulse,
    output int         meas_hold,
    output int         stab_err,
    output int         bus_cycles
);
    int   cs_cnt = 0, wr_cnt = 0, post_cnt = 0;
    logic prev_cs = 1'b1, prev_wr = 1'b1, prev_sel = 1'b0;
    logic [7:0] prev_db = 8'h00;

    initial begin
        lat_a = 8'h00; lat_b = 8'h00;
        meas_setup = 0; meas_pulse = 0; meas_hold = 0; stab_err = 0; bus_cycles = 0;
    end

    always @(negedge clk) begin
        if (cs_n === 1'b0 && wr_n === 1'b0) begin
            if (sel_b) lat_b = db; else lat_a = db;
        end
        if (cs_n !== 1'b0) begin
            if (prev_cs === 1'b0) begin meas_hold = post_cnt; bus_cycles++; end
            cs_cnt = 0; wr_cnt = 0; post_cnt = 0;
        end else begin
            if (prev_cs === 1'b0 && (db !== prev_db || sel_b !== prev_sel)) stab_err++;
            if (wr_n === 1'b0) wr_cnt++;
            if (prev_wr === 1'b0 && wr_n === 1'b1) begin
                meas_setup = cs_cnt; meas_pulse = wr_cnt;
            end
            if (wr_n === 1'b1 && wr_cnt != 0) post_cnt++;
            cs_cnt++;
        end
        prev_cs = cs_n; prev_wr = wr_n; prev_sel = sel_b; prev_db = db;
    end
endmodule

module test_dual_dac_wr_seq;
    localparam int PERIOD_PS = 8000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic       req_valid = 1'b0, w_valid = 1'b0;
    logic       req_chan = 1'b0, req_is_gain = 1'b0;
    logic [7:0] req_value = 8'h00;
    logic       req_ready, busy, done, cs_n, wr_n, sel_b;
    logic [7:0] db;
    logic       w_ready, w_busy, w_done, w_cs_n, w_wr_n, w_sel_b;
    logic [7:0] w_db;

    logic [7:0] lat_a, lat_b, wl_a, wl_b;
    int m_setup, m_pulse, m_hold, m_err, m_cyc;
    int w_setup, w_pulse, w_hold, w_err, w_cyc;

    int tests = 0, fails = 0;
    int cyc = 0;

    dual_dac_wr_seq #(.CLK_PERIOD_PS(PERIOD_PS), .WIDE_TEMP(1'b0)) i_dual_dac_wr_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_chan(req_chan), .req_is_gain(req_is_gain), .req_value(req_value),
        .busy(busy), .done(done), .dac_cs_n(cs_n), .dac_wr_n(wr_n),
        .dac_sel_b(sel_b), .dac_db(db));

    dual_dac_wr_seq #(.CLK_PERIOD_PS(PERIOD_PS), .WIDE_TEMP(1'b1)) i_dual_dac_wr_seq_wide (
        .clk(clk), .rst(rst), .req_valid(w_valid), .req_ready(w_ready),
        .req_chan(req_chan), .req_is_gain(req_is_gain), .req_value(req_value),
        .busy(w_busy), .done(w_done), .dac_cs_n(w_cs_n), .dac_wr_n(w_wr_n),
        .dac_sel_b(w_sel_b), .dac_db(w_db));

    tb_dac_latch_model u_mod (.clk(clk), .cs_n(cs_n), .wr_n(wr_n), .sel_b(sel_b), .db(db),
        .lat_a(lat_a), .lat_b(lat_b), .meas_setup(m_setup), .meas_pulse(m_pulse),
        .meas_hold(m_hold), .stab_err(m_err), .bus_cycles(m_cyc));

    tb_dac_latch_model u_mod_w (.clk(clk), .cs_n(w_cs_n), .wr_n(w_wr_n), .sel_b(w_sel_b), .db(w_db),
        .lat_a(wl_a), .lat_b(wl_b), .meas_setup(w_setup), .meas_pulse(w_pulse),
        .meas_hold(w_hold), .stab_err(w_err), .bus_cycles(w_cyc));

    // Expected timing, from the nanosecond limits of R3..R5 and R12.
    function automatic int ceil_cyc(input int ns);
        return (ns * 1000 + PERIOD_PS - 1) / PERIOD_PS;
    endfunction
    int e_setup, e_pulse, e_hold, e_busy, we_pulse, we_busy;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Issue one write on the standard instance and check it end to end.
    task automatic do_write(input logic chan, input logic gain, input logic [7:0] val,
                            input logic [7:0] exp_code, input string req);
        logic [7:0] other;
        int bcnt, guard, cyc0;
        other = chan ? lat_a : lat_b;
        cyc0  = m_cyc;
        @(negedge clk);
        req_valid = 1'b1; req_chan = chan; req_is_gain = gain; req_value = val;
        @(negedge clk);
        req_valid = 1'b0;
        check(busy === 1'b1 && req_ready === 1'b0, "R2 busy after accept", busy, 1);
        bcnt = 0; guard = 0;
        while (done !== 1'b1 && guard < 500) begin
            if (busy === 1'b1) bcnt++;
            guard++;
            @(negedge clk);
        end
        check(bcnt == e_busy, "R2 busy length", bcnt, e_busy);
        check(done === 1'b1 && busy === 1'b0, "R6 done after busy", done, 1);
        @(negedge clk);
        check(done === 1'b0 && req_ready === 1'b1, "R6 done one cycle", done, 0);
        check((chan ? lat_b : lat_a) == exp_code, req, chan ? lat_b : lat_a, exp_code);
        check((chan ? lat_a : lat_b) == other, "R7 other channel held", chan ? lat_a : lat_b, other);
        check(m_setup >= e_setup, "R3 setup", m_setup, e_setup);
        check(m_pulse == e_pulse, "R4 strobe width", m_pulse, e_pulse);
        check(m_hold >= e_hold, "R5 hold", m_hold, e_hold);
        check(m_err == 0, "R5 bus stable", m_err, 0);
        check(m_cyc == cyc0 + 1, "R2 one bus cycle", m_cyc - cyc0, 1);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(cs_n === 1'b1 && wr_n === 1'b1, "R1 strobes high", {cs_n, wr_n}, 3);
        check(db === 8'h00 && sel_b === 1'b0, "R1 bus zero", db, 0);
        check(busy === 1'b0 && done === 1'b0 && req_ready === 1'b1, "R1 handshake idle",
              {busy, done, req_ready}, 1);
    endtask

    task automatic t_raw();
        do_write(1'b0, 1'b0, 8'hA5, 8'hA5, "R7 R8 raw to A");
        do_write(1'b1, 1'b0, 8'h3C, 8'h3C, "R7 R8 raw to B");
        do_write(1'b0, 1'b0, 8'hFF, 8'hFF, "R8 raw full scale");
        do_write(1'b1, 1'b0, 8'h00, 8'h00, "R8 raw zero");
    endtask

    task automatic t_gain();
        do_write(1'b0, 1'b1, 8'd0,  8'd255, "R9 step 0");
        do_write(1'b1, 1'b1, 8'd12, 8'd128, "R9 step 12");
        do_write(1'b0, 1'b1, 8'd20, 8'd81,  "R9 step 20");
        do_write(1'b1, 1'b1, 8'd24, 8'd64,  "R9 step 24");
        do_write(1'b0, 1'b1, 8'd31, 8'd43,  "R9 step 31");
        do_write(1'b1, 1'b1, 8'd3,  8'd215, "R9 step 3");
    endtask

    task automatic t_sat();
        do_write(1'b0, 1'b1, 8'd32,  8'd43, "R10 step 32");
        do_write(1'b1, 1'b1, 8'd200, 8'd43, "R10 step 200");
    endtask

    task automatic t_ignore();
        logic [7:0] a0, b0;
        int cyc0, guard;
        do_write(1'b0, 1'b0, 8'h11, 8'h11, "R11 setup A");
        do_write(1'b1, 1'b0, 8'h22, 8'h22, "R11 setup B");
        a0 = lat_a; b0 = lat_b; cyc0 = m_cyc;
        @(negedge clk);
        req_valid = 1'b1; req_chan = 1'b0; req_is_gain = 1'b0; req_value = 8'h77;
        @(negedge clk);
        req_chan = 1'b1; req_value = 8'h99;          // stray request while busy
        for (int i = 0; i < 5; i++) begin
            check(req_ready === 1'b0, "R11 not ready while busy", req_ready, 0);
            @(negedge clk);
        end
        req_valid = 1'b0;
        guard = 0;
        while (done !== 1'b1 && guard < 500) begin guard++; @(negedge clk); end
        repeat (4) @(negedge clk);
        check(lat_a == 8'h77, "R11 accepted write lands", lat_a, 8'h77);
        check(lat_b == b0, "R11 stray request ignored", lat_b, b0);
        check(m_cyc == cyc0 + 1, "R11 single bus cycle", m_cyc - cyc0, 1);
        check(a0 == 8'h11, "R11 prior A", a0, 8'h11);
    endtask

    task automatic t_wide();
        int bcnt, guard;
        @(negedge clk);
        w_valid = 1'b1; req_chan = 1'b1; req_is_gain = 1'b1; req_value = 8'd12;
        @(negedge clk);
        w_valid = 1'b0;
        bcnt = 0; guard = 0;
        while (w_done !== 1'b1 && guard < 500) begin
            if (w_busy === 1'b1) bcnt++;
            guard++;
            @(negedge clk);
        end
        @(negedge clk);
        check(w_pulse == we_pulse, "R12 wide strobe width", w_pulse, we_pulse);
        check(bcnt == we_busy, "R12 wide busy length", bcnt, we_busy);
        check(w_setup >= ceil_cyc(210), "R12 wide setup", w_setup, ceil_cyc(210));
        check(wl_b == 8'd128, "R12 wide write lands", wl_b, 128);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            fails++; tests++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        e_setup  = ceil_cyc(160);
        e_pulse  = ceil_cyc(150);
        e_hold   = ceil_cyc(10);
        e_busy   = ((e_setup > e_pulse + 1) ? e_setup : e_pulse + 1) + e_hold;
        we_pulse = ceil_cyc(210);
        we_busy  = ((ceil_cyc(210) > we_pulse + 1) ? ceil_cyc(210) : we_pulse + 1) + e_hold;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_raw();
        t_gain();
        t_sat();
        t_ignore();
        t_wide();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule